// File: doc/BRIEF.md
# Message-Signalled Interrupt Register Bank

This block receives message-signalled interrupts as plain register writes and turns them into level interrupt lines for a parent interrupt controller. A device posts an interrupt by writing one data word to the index register; that word names one of 256 sources. Bits [7:5] select one of eight 32-bit pending groups, and bits [4:0] select a bit inside that group. The addressed pending bit is set. Source n therefore lands in group n/32 at bit n mod 32.

Each group drives one output line. The line is high while its pending register is nonzero and the group's mask bit is clear. A status register shows which groups hold pending bits, whatever the mask. Software services a group by reading its pending register. The read returns the bits and clears them, and that clear is the acknowledge. The bus has separate write and read channels, so an index write and a read-clear can land in the same cycle. In that case the newly posted bit is kept.

Top module: `msi_bank`

## Requirements
- R1: After reset every pending register is 0, the mask register reads 0x000000FF and all eight lines on irq_out are low.
- R2: A write to offset 0x38 sets bit wdata[4:0] of pending group wdata[7:5] and leaves every other pending bit unchanged. Data bits 31:8 have no effect.
- R3: Pending group g is read at offset 4*g (0x00 to 0x1C). rd_data carries the value the register held at the read edge, valid from the cycle after rd_en. The same edge clears the bits that were returned.
- R4: irq_out[g] is 1 exactly when pending group g is nonzero and mask bit g is 0.
- R5: The mask register sits at offset 0x30. A write stores wdata[7:0] into it, and a 1 masks the group. A read returns the mask in bits 7:0 and 0 in bits 31:8.
- R6: The status register at offset 0x34 reads bit g as 1 whenever pending group g is nonzero, whether or not the group is masked. Bits 31:8 read 0.
- R7: When an index write and a read of the same pending group fall in the same cycle, the read returns the old contents, and afterwards the group holds only the newly written bit.
- R8: Writes to offsets 0x00 to 0x1C and to 0x34 change no state. A read of the index register returns 0.
- R9: Successive index writes to one group accumulate. Each one ORs its bit into the group.
- R10: A read of any offset that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| irq_out | output | 8 | Per-group interrupt lines to the parent controller |

## Verification
The hardest case to reach from the ports is the collision between an index write and a read-clear of the same group in one cycle. A single shared bus could never produce it. The bench first posts one bit into a group. It then drives an index write for a different bit of that group on the write channel and, in the same cycle, a read of that group on the read channel. The read must return only the old bit, and a second read must return only the new bit. Masked groups with pending bits are also driven, so that the status register and the output lines can be seen to disagree as intended.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

    localparam int unsigned MAX_GROUPS = 8;
    localparam int unsigned GROUP_BITS = 32;
    localparam int unsigned GRP_IDX_W  = $clog2(MAX_GROUPS);
    localparam int unsigned BIT_IDX_W  = $clog2(GROUP_BITS);

    localparam logic [7:0] OFS_PEND_LAST = 8'h1C;
    localparam logic [7:0] OFS_MASK      = 8'h30;
    localparam logic [7:0] OFS_STATUS    = 8'h34;
    localparam logic [7:0] OFS_INDEX     = 8'h38;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_PEND,
        RSEL_MASK,
        RSEL_STATUS
    } rd_sel_e;

    typedef struct packed {
        logic                 idx_wr;
        logic [GRP_IDX_W-1:0] set_grp;
        logic [BIT_IDX_W-1:0] set_bit;
        logic                 mask_wr;
    } wr_op_t;

    typedef struct packed {
        rd_sel_e              sel;
        logic [GRP_IDX_W-1:0] grp;
    } rd_op_t;

    function automatic logic is_pend_ofs(input logic [7:0] ofs, input int unsigned ngrp);
        return (ofs <= OFS_PEND_LAST) && (ofs[1:0] == 2'b00)
            && (int'(ofs[4:2]) < int'(ngrp));
    endfunction

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_bank_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output wr_op_t            wr_op,
    output rd_op_t            rd_op
);

    logic [GRP_IDX_W-1:0] idx_grp;
    logic [BIT_IDX_W-1:0] idx_bit;

    assign idx_bit = wr_data[BIT_IDX_W-1:0];
    assign idx_grp = wr_data[BIT_IDX_W +: GRP_IDX_W];

    always_comb begin
        wr_op         = '0;
        wr_op.set_grp = idx_grp;
        wr_op.set_bit = idx_bit;
        if (wr_en) begin
            if (wr_addr == OFS_INDEX)
                wr_op.idx_wr = (int'(idx_grp) < int'(NUM_GROUPS));
            if (wr_addr == OFS_MASK)
                wr_op.mask_wr = 1'b1;
        end
    end

    always_comb begin
        rd_op.sel = RSEL_NONE;
        rd_op.grp = rd_addr[2 +: GRP_IDX_W];
        if (rd_en) begin
            if (is_pend_ofs(rd_addr, NUM_GROUPS))
                rd_op.sel = RSEL_PEND;
            else if (rd_addr == OFS_MASK)
                rd_op.sel = RSEL_MASK;
            else if (rd_addr == OFS_STATUS)
                rd_op.sel = RSEL_STATUS;
        end
    end

endmodule

// File: rtl/msi_pend_group.sv
module msi_pend_group #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned POS_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [POS_W-1:0] set_pos,
    input  logic             clr_en,
    output logic [WIDTH-1:0] pend,
    output logic             any
);

    logic [WIDTH-1:0] pend_n;

    always_comb begin
        pend_n = clr_en ? '0 : pend;
        if (set_en)
            pend_n[set_pos] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= pend_n;
    end

    assign any = |pend;

endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
    import msi_bank_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned DATA_W     = 32
) (
    input  rd_op_t                                rd_op,
    input  logic [NUM_GROUPS-1:0][GROUP_BITS-1:0] pend,
    input  logic [NUM_GROUPS-1:0]                 mask,
    input  logic [NUM_GROUPS-1:0]                 any,
    output logic [DATA_W-1:0]                     rdata
);

    logic [GROUP_BITS-1:0] pend_sel;

    always_comb begin
        pend_sel = '0;
        for (int g = 0; g < int'(NUM_GROUPS); g++)
            if (int'(rd_op.grp) == g)
                pend_sel = pend[g];
    end

    always_comb begin
        unique case (rd_op.sel)
            RSEL_PEND:   rdata = DATA_W'(pend_sel);
            RSEL_MASK:   rdata = DATA_W'(mask);
            RSEL_STATUS: rdata = DATA_W'(any);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/msi_bank.sv
module msi_bank
    import msi_bank_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_GROUPS-1:0] irq_out
);

    wr_op_t                                wr_op;
    rd_op_t                                rd_op;
    logic [NUM_GROUPS-1:0][GROUP_BITS-1:0] pend_q;
    logic [NUM_GROUPS-1:0]                 any_q;
    logic [NUM_GROUPS-1:0]                 mask_q;
    logic [DATA_W-1:0]                     rdata_n;

    msi_reg_decode #(
        .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_op(wr_op), .rd_op(rd_op)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit_set;
        logic hit_clr;
        assign hit_set = wr_op.idx_wr && (int'(wr_op.set_grp) == g);
        assign hit_clr = (rd_op.sel == RSEL_PEND) && (int'(rd_op.grp) == g);

        msi_pend_group #(.WIDTH(GROUP_BITS)) u_pend (
            .clk(clk), .rst(rst),
            .set_en(hit_set), .set_pos(wr_op.set_bit),
            .clr_en(hit_clr),
            .pend(pend_q[g]), .any(any_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (wr_op.mask_wr)
            mask_q <= wr_data[NUM_GROUPS-1:0];
    end

    msi_read_mux #(.NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W)) u_rmux (
        .rd_op(rd_op), .pend(pend_q), .mask(mask_q), .any(any_q), .rdata(rdata_n)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rdata_n;
    end

    assign irq_out = any_q & ~mask_q;

endmodule

// File: rtl/msi_bank_chk.sv
module msi_bank_chk
    import msi_bank_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                wr_en,
    input logic [ADDR_W-1:0]                   wr_addr,
    input logic [DATA_W-1:0]                   wr_data,
    input logic                                rd_en,
    input logic [ADDR_W-1:0]                   rd_addr,
    input logic [DATA_W-1:0]                   rd_data,
    input logic [NUM_GROUPS-1:0]               irq_out,
    input logic [NUM_GROUPS-1:0][GROUP_BITS-1:0] pend_q,
    input logic [NUM_GROUPS-1:0]               mask_q
);

    logic                  posted;
    logic [GRP_IDX_W-1:0]  posted_grp;
    logic [BIT_IDX_W-1:0]  posted_bit;
    logic [NUM_GROUPS-1:0] cleared;

    always_ff @(posedge clk) begin
        if (rst) begin
            posted  <= 1'b0;
            cleared <= '0;
        end else begin
            posted     <= wr_en && (wr_addr == OFS_INDEX)
                       && (int'(wr_data[BIT_IDX_W +: GRP_IDX_W]) < int'(NUM_GROUPS));
            posted_grp <= wr_data[BIT_IDX_W +: GRP_IDX_W];
            posted_bit <= wr_data[BIT_IDX_W-1:0];
            for (int g = 0; g < int'(NUM_GROUPS); g++)
                cleared[g] <= rd_en && (rd_addr == ADDR_W'(4 * g))
                           && !(wr_en && (wr_addr == OFS_INDEX)
                                && (int'(wr_data[BIT_IDX_W +: GRP_IDX_W]) == g));
        end
    end

    AST_INDEX_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
        posted |-> pend_q[posted_grp][posted_bit]); // R2

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_clr
        AST_READ_CLEARS_GROUP: assert property (@(posedge clk) disable iff (rst)
            cleared[g] |-> (pend_q[g] == '0)); // R3
    end

    AST_MASKED_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        (irq_out & mask_q) == '0); // R4

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == OFS_STATUS) |=> ((rd_data >> NUM_GROUPS) == '0)); // R6

    AST_INDEX_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == OFS_INDEX) |=> (rd_data == '0)); // R8

endmodule

bind msi_bank msi_bank_chk #(
    .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out),
    .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/msi_bank_tb.sv
module msi_bank_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic [7:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    msi_bank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1", "irq after reset", 32'(irq_out), 32'h0);
        bus_read(8'h30, v); check("R1", "mask after reset", v, 32'h0000_00FF);
        bus_read(8'h34, v); check("R1", "status after reset", v, 32'h0);
        bus_read(8'h1C, v); check("R1", "pending7 after reset", v, 32'h0);
    endtask

    task automatic t_index_and_mask();
        logic [31:0] v;
        bus_write(8'h38, 32'hABCD_0045);          // group 2, bit 5
        bus_read(8'h34, v); check("R6", "status masked group2", v, 32'h0000_0004);
        check("R4", "masked line low", 32'(irq_out), 32'h0);
        bus_write(8'h30, 32'hFFFF_FFFB);
        bus_read(8'h30, v); check("R5", "mask readback", v, 32'h0000_00FB);
        check("R4", "unmasked group2 line", 32'(irq_out), 32'h0000_0004);
        bus_read(8'h08, v); check("R2", "pending2 holds bit5 only", v, 32'h0000_0020);
        check("R3", "line drops after read", 32'(irq_out), 32'h0);
        bus_read(8'h08, v); check("R3", "pending2 cleared by read", v, 32'h0);
    endtask

    task automatic t_accumulate();
        logic [31:0] v;
        bus_write(8'h30, 32'h0);
        bus_write(8'h38, 32'h0000_00FF);          // source 255
        bus_write(8'h38, 32'h0000_00E0);          // source 224
        check("R4", "group7 line", 32'(irq_out), 32'h0000_0080);
        bus_read(8'h1C, v); check("R9", "pending7 accumulates", v, 32'h8000_0001);
        bus_read(8'h34, v); check("R3", "status clear after read", v, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        bus_write(8'h38, 32'h0000_0043);          // group 2, bit 3
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h38; wr_data = 32'h0000_0049; // group 2, bit 9
        rd_en = 1'b1; rd_addr = 8'h08;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R7", "collision read returns old", rd_data, 32'h0000_0008);
        check("R7", "line stays up for new bit", 32'(irq_out), 32'h0000_0004);
        bus_read(8'h08, v); check("R7", "new bit survives", v, 32'h0000_0200);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        bus_write(8'h30, 32'h0000_00FF);
        bus_write(8'h38, 32'h0000_0001);          // group 0, bit 1
        bus_read(8'h34, v); check("R6", "status ignores mask", v, 32'h0000_0001);
        check("R4", "masked group0 low", 32'(irq_out), 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_read(8'h34, v); check("R8", "status after ignored writes", v, 32'h0000_0001);
        bus_read(8'h04, v); check("R8", "pending1 not written", v, 32'h0);
        bus_read(8'h38, v); check("R8", "index reads zero", v, 32'h0);
        bus_read(8'h3C, v); check("R10", "unmapped 0x3C", v, 32'h0);
        bus_read(8'h22, v); check("R10", "unmapped 0x22", v, 32'h0);
        bus_read(8'h00, v); check("R3", "pending0 contents", v, 32'h0000_0002);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_index_and_mask();
        t_accumulate();
        t_same_cycle();
        t_ignored();
        finish_run();
    end

endmodule